// File: doc/BRIEF.md
# Framed 3x3 Convolution Engine

This engine filters a whole image frame that sits in an on-chip memory. The kernel is 3x3 and holds signed integer coefficients. The result frame has the same size as the input and goes to an output memory. A single start pulse begins a run. The engine then visits every output pixel in raster order. For each pixel it fetches the nine neighbours together with the matching coefficients, one pair per cycle, and adds up their products. After the ninth product it writes one saturated result word.

Operands come from word-addressed memories that answer one cycle after the address is presented. The datapath therefore carries a tap's flags one stage alongside the read. Pixels on the frame edge see zero for every neighbour that falls outside the frame. Typical loads are horizontal and vertical gradient kernels with coefficients of +1, 0 and -1. Any signed 32-bit coefficients are accepted.

Top module: `conv3x3_frame_engine`

## Requirements
- R1: After reset, `busy`, `done` and `out_we` are all low.
- R2: Suppose `start` is high on a clock edge while `busy` is low. Then `busy` is high after that edge. `start` has no effect while `busy` is high. A pulse in the middle of a run neither restarts the run nor adds writes.
- R3: A run writes each of the COLS*ROWS output words exactly once. The writes go in raster order, with `out_addr` = row*COLS + col, and one pixel is written every nine cycles.
- R4: The result at (row, col) is the sum over krow, kcol in 0..2 of coef[krow*3+kcol] * img[(row+krow-1)*COLS + (col+kcol-1)]. `coef_addr` = krow*3+kcol. Pixels and coefficients are signed 32-bit integers. This covers horizontal and vertical +1/0/-1 gradient kernels.
- R5: A neighbour outside the frame counts as zero. Corner and edge pixels therefore sum only over their in-frame neighbours.
- R6: The sum is kept at full precision and clamped to the signed 32-bit range on write. Overflow gives 0x7FFFFFFF and underflow gives 0x80000000.
- R7: `done` is high for exactly one cycle, one cycle after the last write. `busy` is low in that same cycle. Counting from the edge that accepts `start`, `done` rises 9*COLS*ROWS+2 edges later.
- R8: Image and coefficient addresses are issued in the same cycle, and their read data is used in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame run (ignored while busy) |
| img_addr | output | $clog2(COLS*ROWS) | Image memory read address |
| img_rdata | input | 32 | Image word, one cycle after its address |
| coef_addr | output | 4 | Kernel memory read address (0..8) |
| coef_rdata | input | 32 | Coefficient word, one cycle after its address |
| out_we | output | 1 | Result write strobe |
| out_addr | output | $clog2(COLS*ROWS) | Result write address |
| out_wdata | output | 32 | Saturated result word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench uses a non-square frame so that a swapped row and column would show up. It checks several image and kernel pairs against a golden sum computed in the bench.

A horizontal and a vertical gradient kernel over a ramp and over a scrambled signed image separate the two axes and the sign handling. A kernel whose nine coefficients all differ, over an image that encodes row and column, catches a flipped or transposed tap order. Frames filled with the extreme values check clamping in both directions. Corner pixels are checked on their own to confirm the zero border. One run receives an extra start pulse in the middle, and the bench checks that the write count and the done timing are unchanged.

// File: rtl/conv3x3_frame_engine.sv
module conv3x3_frame_engine #(
  parameter int COLS = 96,
  parameter int ROWS = 96,
  parameter int DW   = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  output logic [$clog2(COLS*ROWS)-1:0]        img_addr,
  input  logic [DW-1:0]                       img_rdata,
  output logic [3:0]                          coef_addr,
  input  logic [DW-1:0]                       coef_rdata,
  output logic                                out_we,
  output logic [$clog2(COLS*ROWS)-1:0]        out_addr,
  output logic [DW-1:0]                       out_wdata,
  output logic                                busy,
  output logic                                done
);
  localparam int NPIX = COLS * ROWS;
  localparam int AW   = $clog2(NPIX);
  localparam int CW   = $clog2(COLS);
  localparam int RW   = $clog2(ROWS);
  localparam int ACCW = 2 * DW + 4;

  logic          run;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [1:0]    kr, kc;

  logic [RW:0]   nr_p1;
  logic [CW:0]   nc_p1;
  logic          inb;
  logic [AW-1:0] nbr_addr, pix_addr;

  assign nr_p1    = {1'b0, row} + (RW+1)'(kr);
  assign nc_p1    = {1'b0, col} + (CW+1)'(kc);
  assign inb      = (nr_p1 != '0) && (nr_p1 <= (RW+1)'(ROWS)) &&
                    (nc_p1 != '0) && (nc_p1 <= (CW+1)'(COLS));
  assign nbr_addr = AW'(nr_p1 - 1'b1) * AW'(COLS) + AW'(nc_p1 - 1'b1);
  assign pix_addr = AW'(row) * AW'(COLS) + AW'(col);
  assign img_addr = inb ? nbr_addr : '0;
  assign coef_addr = {2'b00, kr} * 4'd3 + {2'b00, kc};

  logic          p_v, p_inb, p_first, p_last, p_final;
  logic [AW-1:0] p_oaddr;
  logic          out_final;

  logic signed [2*DW-1:0] prod;
  logic signed [ACCW-1:0] acc, acc_base, acc_next;
  logic [ACCW-DW:0]       hi;
  logic [DW-1:0]          sat;

  assign prod     = $signed(img_rdata) * $signed(coef_rdata);
  assign acc_base = p_first ? '0 : acc;
  assign acc_next = acc_base + (p_inb ? ACCW'(prod) : '0);
  assign hi       = acc_next[ACCW-1:DW-1];
  assign sat      = (&hi || ~|hi) ? acc_next[DW-1:0] :
                    acc_next[ACCW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      busy <= 1'b0;
      row  <= '0;
      col  <= '0;
      kr   <= '0;
      kc   <= '0;
    end else begin
      if (start && !busy) begin
        run  <= 1'b1;
        busy <= 1'b1;
        row  <= '0;
        col  <= '0;
        kr   <= '0;
        kc   <= '0;
      end else if (run) begin
        if (kc == 2'd2) begin
          kc <= '0;
          if (kr == 2'd2) begin
            kr <= '0;
            if (col == CW'(COLS - 1)) begin
              col <= '0;
              if (row == RW'(ROWS - 1)) run <= 1'b0;
              else                      row <= row + 1'b1;
            end else begin
              col <= col + 1'b1;
            end
          end else begin
            kr <= kr + 1'b1;
          end
        end else begin
          kc <= kc + 1'b1;
        end
      end
      if (out_we && out_final) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_v    <= 1'b0;
      out_we <= 1'b0;
      done   <= 1'b0;
    end else begin
      p_v    <= run;
      out_we <= p_v && p_last;
      done   <= out_we && out_final;
    end
  end

  always_ff @(posedge clk) begin
    p_inb     <= inb;
    p_first   <= (kr == 2'd0) && (kc == 2'd0);
    p_last    <= (kr == 2'd2) && (kc == 2'd2);
    p_oaddr   <= pix_addr;
    p_final   <= pix_addr == AW'(NPIX - 1);
    if (p_v) acc <= acc_next;
    out_addr  <= p_oaddr;
    out_wdata <= sat;
    out_final <= p_final;
  end
endmodule

// File: rtl/conv3x3_frame_engine_chk.sv
module conv3x3_frame_engine_chk #(
  parameter int COLS = 96,
  parameter int ROWS = 96,
  parameter int DW   = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start,
  input logic                         busy,
  input logic                         done,
  input logic                         out_we,
  input logic [$clog2(COLS*ROWS)-1:0] out_addr,
  input logic [3:0]                   coef_addr
);
  localparam int NPIX = COLS * ROWS;
  localparam int AW   = $clog2(NPIX);

  logic [AW:0] exp_addr;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) exp_addr <= '0;
    else if (out_we)     exp_addr <= exp_addr + 1'b1;
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_start_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_raster_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> (busy && out_addr == exp_addr[AW-1:0]));
  assert_write_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> exp_addr == (AW+1)'(NPIX));
  assert_coef_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> coef_addr < 4'd9);
endmodule

bind conv3x3_frame_engine conv3x3_frame_engine_chk #(.COLS(COLS), .ROWS(ROWS), .DW(DW)) u_chk (.*);

// File: tb/conv3x3_frame_engine_tb.sv
`timescale 1ns/1ps
module conv3x3_frame_engine_tb;
  localparam int COLS = 16;
  localparam int ROWS = 12;
  localparam int N    = COLS * ROWS;
  localparam int AW   = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] img_addr, out_addr;
  logic [3:0]    coef_addr;
  logic [31:0]   img_rdata, coef_rdata, out_wdata;
  logic          out_we, busy, done;

  logic [31:0] img_mem [N];
  logic [31:0] coef_mem [9];
  logic [31:0] res [N];
  int wr_cnt, done_cnt, checks, errors;

  always #2 clk = ~clk;

  conv3x3_frame_engine #(.COLS(COLS), .ROWS(ROWS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .img_addr(img_addr), .img_rdata(img_rdata),
    .coef_addr(coef_addr), .coef_rdata(coef_rdata),
    .out_we(out_we), .out_addr(out_addr), .out_wdata(out_wdata),
    .busy(busy), .done(done));

  always @(posedge clk) begin
    img_rdata  <= (int'(img_addr) < N) ? img_mem[img_addr] : 32'hxxxx_xxxx;
    coef_rdata <= (coef_addr < 4'd9) ? coef_mem[coef_addr] : 32'hxxxx_xxxx;
  end

  always @(negedge clk) begin
    if (out_we) begin
      res[out_addr] = out_wdata;
      wr_cnt++;
    end
    if (done) done_cnt++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gold(int r, int c);
    longint s = 0;
    for (int kr = 0; kr < 3; kr++)
      for (int kc = 0; kc < 3; kc++) begin
        int nr = r + kr - 1;
        int nc = c + kc - 1;
        if (nr >= 0 && nr < ROWS && nc >= 0 && nc < COLS)
          s += longint'($signed(img_mem[nr*COLS+nc])) * longint'($signed(coef_mem[kr*3+kc]));
      end
    if (s > 64'sd2147483647)  return 32'h7fff_ffff;
    if (s < -64'sd2147483648) return 32'h8000_0000;
    return s[31:0];
  endfunction

  task automatic run_frame(bit inject);
    int cyc = 0;
    wr_cnt = 0;
    done_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R2 busy after start", 32'(busy), 32'd1);
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start = inject && (cyc == 50);
    end
    start = 1'b0;
    check("R7 done edge count", 32'(cyc), 32'(9*N+2));
    check("R7 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    check("R7 done single cycle", 32'(done), 32'd0);
    check("R3 write count", 32'(wr_cnt), 32'(N));
    check("R7 done pulse count", 32'(done_cnt), 32'd1);
  endtask

  task automatic check_frame(string req);
    int bad = 0;
    logic [31:0] fa = '0, fe = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (res[r*COLS+c] !== gold(r, c)) begin
          if (bad == 0) begin fa = res[r*COLS+c]; fe = gold(r, c); end
          bad++;
        end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s frame: %0d mismatches, first actual %h expected %h", req, bad, fa, fe);
    end
    check("R5 corner top-left", res[0], gold(0, 0));
    check("R5 corner bottom-right", res[N-1], gold(ROWS-1, COLS-1));
    check("R5 edge top-right", res[COLS-1], gold(0, COLS-1));
  endtask

  task automatic t_reset;
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 out_we", 32'(out_we), 32'd0);
  endtask

  task automatic t_hgrad;
    for (int i = 0; i < N; i++) img_mem[i] = 32'((i / COLS) * 7 + (i % COLS) * 3 - 20);
    coef_mem = '{1, 1, 1, 0, 0, 0, -1, -1, -1};
    run_frame(0);
    check_frame("R4 horizontal gradient");
  endtask

  task automatic t_vgrad;
    for (int i = 0; i < N; i++) img_mem[i] = 32'(((i * 37 + 11) % 201) - 100);
    coef_mem = '{1, 0, -1, 1, 0, -1, 1, 0, -1};
    run_frame(0);
    check_frame("R4 vertical gradient");
  endtask

  task automatic t_orient;
    for (int i = 0; i < N; i++) img_mem[i] = 32'((i / COLS) * 100 + (i % COLS));
    for (int k = 0; k < 9; k++) coef_mem[k] = 32'((k + 1) * (k + 1));
    run_frame(0);
    check_frame("R4 R8 tap order");
  endtask

  task automatic t_saturate;
    for (int i = 0; i < N; i++) img_mem[i] = 32'h7fff_ffff;
    for (int k = 0; k < 9; k++) coef_mem[k] = 32'd1;
    run_frame(0);
    check("R6 positive clamp", res[N/2], 32'h7fff_ffff);
    check_frame("R6 positive");
    for (int k = 0; k < 9; k++) coef_mem[k] = 32'hffff_ffff;
    run_frame(0);
    check("R6 negative clamp", res[N/2], 32'h8000_0000);
    check_frame("R6 negative");
  endtask

  task automatic t_start_busy;
    for (int i = 0; i < N; i++) img_mem[i] = 32'(i % 13 - 6);
    coef_mem = '{0, -1, 0, -1, 4, -1, 0, -1, 0};
    run_frame(1);
    check_frame("R2 start ignored while busy");
  endtask

  initial begin
    #700us;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_hgrad;
    t_vgrad;
    t_orient;
    t_saturate;
    t_start_busy;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule